// File: doc/BRIEF.md
# SM3 Message Expansion Unit

This unit turns one 512-bit message block into the per-round word pair needed by an SM3 compression core. A producer hands over the block as 64 bytes on a valid/ready handshake. The unit then presents, for rounds 0 through 63, the expanded word W[j] and the paired word W'[j] = W[j] XOR W[j+4]. The consumer steps from one round to the next by pulsing an advance input.

Storage is a sliding window of sixteen 32-bit words holding W[j] to W[j+15]. On every advance the window drops its oldest word and appends one new word computed from five taps of the window. W[j+4] is therefore always present, and the 68-entry expanded array is never stored.

After round 63 is consumed, the unit goes idle and can accept the next block. While a block is being expanded, load requests are refused.

Top module: `sm3_wexp`

## Requirements
- R1: After a synchronous active-low reset, `pair_valid` and `last_pair` are 0 and `blk_ready` is 1.
- R2: The block is split into sixteen big-endian words: W[0] = `blk_data[511:480]`, and W[i] = `blk_data[511-32*i -: 32]`, so byte 0 of each word is its most significant byte. One cycle after `blk_valid` and `blk_ready` are both high, `pair_valid` is 1, `round_idx` is 0 and `w_out` equals W[0].
- R3: For round j from 16 up, `w_out` is P1(W[j-16] ^ W[j-9] ^ rol(W[j-3],15)) ^ rol(W[j-13],7) ^ W[j-6], where P1(x) = x ^ rol(x,15) ^ rol(x,23).
- R4: In every valid round j, `wp_out` equals W[j] ^ W[j+4]. This covers rounds 60 to 63, which need words up to W[67].
- R5: While `pair_valid` is 1 and `adv` is 0, `w_out`, `wp_out` and `round_idx` hold their values. Each cycle with `adv` high moves to the next round, one cycle later.
- R6: `last_pair` is 1 exactly when `round_idx` is 63 and `pair_valid` is 1. Advancing from round 63 drops `pair_valid` to 0 and raises `blk_ready` on the next cycle.
- R7: `blk_ready` is 0 while a block is being expanded. A `blk_valid` in that time has no effect on `w_out`, `wp_out` or `round_idx`.
- R8: Once idle again, the unit accepts a new block and expands it from round 0, with no state carried over from the previous block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_valid | input | 1 | Producer offers a block |
| blk_ready | output | 1 | Unit can take a block (idle) |
| blk_data | input | 512 | Message block, byte 0 in bits 511:504 |
| adv | input | 1 | Consumer has used the current pair |
| pair_valid | output | 1 | `w_out`/`wp_out` hold a valid round pair |
| round_idx | output | 6 | Round number of the current pair |
| w_out | output | 32 | W[j] |
| wp_out | output | 32 | W[j] XOR W[j+4] |
| last_pair | output | 1 | Current pair is round 63 |

## Verification
The hardest case to reach from the ports is a load request that arrives mid-expansion while the consumer is stalled. In that situation a wrong design would overwrite the window with no visible effect until several rounds later. The stimulus inserts random stall gaps between advances and, during them, randomly raises `blk_valid` with fresh data. It checks that the current pair and round number stay frozen. Every round of every block is then compared with a bench model of the expansion, so a corrupted window also shows up in the later words.

// File: rtl/sm3_wexp_pkg.sv
// Package: shared word type, window tap positions and the bit-mixing
// helpers of the SM3 message expansion.
// Assumes a 32-bit word, which the algorithm fixes.
package sm3_wexp_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    // Window positions (relative to the current round j) feeding W[j+16]
    localparam int TAP_M16 = 0;   // W[j]
    localparam int TAP_M13 = 3;   // W[j+3]
    localparam int TAP_M9  = 7;   // W[j+7]
    localparam int TAP_M6  = 10;  // W[j+10]
    localparam int TAP_M3  = 13;  // W[j+13]
    localparam int AHEAD   = 4;   // partner distance for the paired word

    // Rotate a word left by s bits
    function automatic word_t rotl(input word_t x, input int unsigned s);
        return (x << s) | (x >> (WORD_W - s));
    endfunction

    // Linear permutation used by the expansion
    function automatic word_t perm1(input word_t x);
        return x ^ rotl(x, 15) ^ rotl(x, 23);
    endfunction
endpackage

// File: rtl/sm3_wexp_next.sv
// Module: combinational generator of the next expanded word.
// Given the five tap words of the current window, returns the word that
// lies sixteen positions after the window head. Pure logic, no state.
module sm3_wexp_next
    import sm3_wexp_pkg::*;
(
    input  word_t t_m16,
    input  word_t t_m13,
    input  word_t t_m9,
    input  word_t t_m6,
    input  word_t t_m3,
    output word_t w_new
);
    word_t mix;

    // Five-tap recurrence through the permutation
    always_comb begin
        mix   = t_m16 ^ t_m9 ^ rotl(t_m3, 15);
        w_new = perm1(mix) ^ rotl(t_m13, 7) ^ t_m6;
    end
endmodule

// File: rtl/sm3_wexp_ctrl.sv
// Module: round sequencer. Tracks whether a block is being expanded and
// which round is presented. Assumes the consumer's adv is only meaningful
// while active; a load is taken only while idle.
module sm3_wexp_ctrl #(
    parameter int ROUNDS = 64,
    localparam int RW = $clog2(ROUNDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    output logic          active,
    output logic [RW-1:0] round,
    output logic          last
);
    localparam logic [RW-1:0] LAST_RND = RW'(ROUNDS - 1);

    // Busy flag and round counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            round  <= '0;
        end else if (load) begin
            active <= 1'b1;
            round  <= '0;
        end else if (active && adv) begin
            if (round == LAST_RND) active <= 1'b0;
            else                   round  <= round + 1'b1;
        end
    end

    assign last = active && (round == LAST_RND);

    assert_last_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (last && adv) |=> !active);
    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && adv && !last) |=> (round == $past(round) + 1'b1));
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !adv) |=> (active && $stable(round)));
endmodule

// File: rtl/sm3_wexp.sv
// Module: SM3 message expansion top. Loads a 512-bit block into a
// 16-word sliding window (big-endian words) and presents W[j] and
// W[j]^W[j+4] for each round. Assumes the consumer samples the pair
// while pair_valid is high and pulses adv to move on.
module sm3_wexp
    import sm3_wexp_pkg::*;
#(
    parameter int WIN_WORDS = 16,
    parameter int ROUNDS    = 64,
    localparam int BLK_W = WIN_WORDS * WORD_W,
    localparam int RW    = $clog2(ROUNDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_valid,
    output logic              blk_ready,
    input  logic [BLK_W-1:0]  blk_data,
    input  logic              adv,
    output logic              pair_valid,
    output logic [RW-1:0]     round_idx,
    output logic [WORD_W-1:0] w_out,
    output logic [WORD_W-1:0] wp_out,
    output logic              last_pair
);
    word_t win_q [WIN_WORDS];
    word_t w_new;
    logic  active, last, load;

    assign blk_ready = !active;
    assign load      = blk_valid && !active;

    sm3_wexp_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .adv    (adv),
        .active (active),
        .round  (round_idx),
        .last   (last)
    );

    sm3_wexp_next u_next (
        .t_m16 (win_q[TAP_M16]),
        .t_m13 (win_q[TAP_M13]),
        .t_m9  (win_q[TAP_M9]),
        .t_m6  (win_q[TAP_M6]),
        .t_m3  (win_q[TAP_M3]),
        .w_new (w_new)
    );

    // Window: parallel load of the block or shift-and-append on advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN_WORDS; i++) win_q[i] <= '0;
        end else if (load) begin
            for (int i = 0; i < WIN_WORDS; i++)
                win_q[i] <= blk_data[BLK_W-1-i*WORD_W -: WORD_W];
        end else if (active && adv && !last) begin
            for (int i = 0; i < WIN_WORDS-1; i++) win_q[i] <= win_q[i+1];
            win_q[WIN_WORDS-1] <= w_new;
        end
    end

    assign pair_valid = active;
    assign last_pair  = last;
    assign w_out      = win_q[0];
    assign wp_out     = win_q[0] ^ win_q[AHEAD];

    assert_load_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && blk_ready) |=> (pair_valid && round_idx == '0
                                      && w_out == $past(blk_data[BLK_W-1 -: WORD_W])));
    assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && adv && !last_pair) |=> (w_out == $past(win_q[1])));
    assert_append_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && adv && !last_pair) |=> (win_q[WIN_WORDS-1] == $past(w_new)));
    assert_ignore_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && blk_valid && !adv) |=> ($stable(w_out) && $stable(wp_out)));
    assert_last_round_R6: assert property (@(posedge clk) disable iff (!rst_n)
        last_pair |-> (pair_valid && round_idx == RW'(ROUNDS-1)));
endmodule

// File: tb/sm3_wexp_bench.sv
`timescale 1ns/1ps
module sm3_wexp_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         blk_valid = 1'b0;
    logic         blk_ready;
    logic [511:0] blk_data = '0;
    logic         adv = 1'b0;
    logic         pair_valid;
    logic [5:0]   round_idx;
    logic [31:0]  w_out, wp_out;
    logic         last_pair;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] ref_w [0:67];

    always #10 clk = ~clk;

    sm3_wexp u_sm3_wexp (
        .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_ready(blk_ready),
        .blk_data(blk_data), .adv(adv), .pair_valid(pair_valid),
        .round_idx(round_idx), .w_out(w_out), .wp_out(wp_out),
        .last_pair(last_pair)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int s);
        return (x << s) | (x >> (32 - s));
    endfunction

    // Reference expansion of the whole 68-word array
    task automatic build_ref(input logic [511:0] blk);
        for (int i = 0; i < 16; i++) ref_w[i] = blk[511-32*i -: 32];
        for (int j = 16; j < 68; j++) begin
            logic [31:0] x;
            x = ref_w[j-16] ^ ref_w[j-9] ^ rl(ref_w[j-3], 15);
            ref_w[j] = (x ^ rl(x, 15) ^ rl(x, 23)) ^ rl(ref_w[j-13], 7) ^ ref_w[j-6];
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Run one block through all rounds with random stalls and stray loads
    task automatic run_block(input logic [511:0] blk, input bit stalls);
        build_ref(blk);
        @(negedge clk);
        chk("R8 ready before load", 32'(blk_ready), 32'd1);
        blk_valid = 1'b1;
        blk_data  = blk;
        @(posedge clk);
        @(negedge clk);
        blk_valid = 1'b0;
        chk("R2 valid after load", 32'(pair_valid), 32'd1);
        chk("R2 round zero", 32'(round_idx), 32'd0);
        for (int j = 0; j < 64; j++) begin
            chk(j < 16 ? "R2 word order" : "R3 expanded word", w_out, ref_w[j]);
            chk("R4 paired word", wp_out, ref_w[j] ^ ref_w[j+4]);
            chk("R5 round index", 32'(round_idx), 32'(j));
            chk("R6 last flag", 32'(last_pair), (j == 63) ? 32'd1 : 32'd0);
            if (stalls) begin
                int gap = int'($urandom % 3);
                for (int k = 0; k < gap; k++) begin
                    blk_valid = 1'($urandom % 2);
                    blk_data  = {16{$urandom}};
                    @(posedge clk);
                    @(negedge clk);
                    chk("R7 ready low while busy", 32'(blk_ready), 32'd0);
                    chk("R7 word held", w_out, ref_w[j]);
                    chk("R5 round held", 32'(round_idx), 32'(j));
                end
                blk_valid = 1'b0;
            end
            adv = 1'b1;
            @(posedge clk);
            @(negedge clk);
            adv = 1'b0;
        end
        chk("R6 valid drops after last", 32'(pair_valid), 32'd0);
        chk("R6 ready returns", 32'(blk_ready), 32'd1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset valid", 32'(pair_valid), 32'd0);
        chk("R1 reset ready", 32'(blk_ready), 32'd1);
        chk("R1 reset last", 32'(last_pair), 32'd0);
        rst_n = 1'b1;
        // Directed: all zero, all ones, byte-counting pattern
        run_block('0, 1'b0);
        run_block({512{1'b1}}, 1'b1);
        begin
            logic [511:0] pat;
            for (int b = 0; b < 64; b++) pat[511-8*b -: 8] = 8'(b);
            run_block(pat, 1'b1);
        end
        // Random blocks, back to back (R8)
        for (int n = 0; n < 4; n++) begin
            logic [511:0] rb;
            for (int i = 0; i < 16; i++) rb[511-32*i -: 32] = $urandom;
            run_block(rb, 1'b1);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule